// File: doc/BRIEF.md
# Training Mailbox Handshake Reader

This block is a register-bus master that empties the message mailbox of a memory-PHY training engine and reports whether training passed. Once it is started, it polls a status register until a message is waiting, reads the message, and then acknowledges it in two steps before it polls again. Major messages are single 32-bit words. A streaming message is announced by a major code. It carries a header word whose low half gives the number of argument words that follow. Each streaming word is built from two 16-bit mailbox reads.

Every word the block receives appears on a tagged output for one cycle. The tag marks the word as a major code, a stream header or a stream argument. The passing and failing terminal codes stop the reader and raise sticky result flags. An optional poll limit turns an engine that stays silent into a failure.

Top module: `mboxReader`

## Requirements
- R1: The status register at offset 0xd0004 is read repeatedly until its bit 0 reads 0, which means a message is pending. No mail data register is read until a pending status has been seen.
- R2: A major message is the full 32-bit value read from offset 0xd0032.
- R3: A streaming word is {bits 15:0 read from 0xd0034, bits 15:0 read from 0xd0032}. The upper half of each read is ignored.
- R4: After every message read, the block writes 0 to offset 0xd0031. It then reads the status register until bit 0 reads 1, and then writes 1 to 0xd0031. All of this happens before the next poll.
- R5: Major code 0x07 sets done and pass, and the reader issues no further bus requests.
- R6: Major code 0xff sets done and fail, and the reader issues no further bus requests. Pass and fail are never set together.
- R7: Major code 0x08 makes the next word a stream header. The header's bits 15:0 give the number of argument words that follow, and 0 is allowed. Arguments are never interpreted as codes.
- R8: Any other major code is reported and then ignored, and polling for the next major message resumes.
- R9: Each received word is presented on msgWord with msgValid high for exactly one cycle. msgTag is 0 for a major code, 1 for a stream header and 2 for a stream argument.
- R10: If pollLimit is nonzero, pollLimit consecutive status reads without a pending message end the run with done and fail. A pollLimit of 0 disables this limit. The poll count restarts with every message.
- R11: done, pass and fail hold until the next accepted start, and that start clears them. A start pulse while the reader is running is ignored.
- R12: A synchronous active-high reset returns the reader to idle with every flag, msgValid and busReq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| pollLimit | input | 16 | Allowed idle polls per message (0 = unlimited) |
| busReq | output | 1 | Bus transaction request, held until busReady |
| busWe | output | 1 | Write when high, read when low |
| busAddr | output | 20 | Register offset |
| busWdata | output | 32 | Write data |
| busReady | input | 1 | Transaction completes this cycle |
| busRdata | input | 32 | Read data, valid with busReady |
| msgValid | output | 1 | One-cycle strobe for a received word |
| msgTag | output | 2 | 0 major, 1 header, 2 argument |
| msgWord | output | 32 | Received word |
| done | output | 1 | Run finished |
| pass | output | 1 | Training passed |
| fail | output | 1 | Training failed or timed out |

## Verification
The bench runs short major-only sequences ending in each terminal code. It also runs a sequence of unknown codes, which separates ignoring a code from acting on it. A sweep of stream headers with argument counts 0 to 4 uses arguments equal to 0x07 and 0xff, which shows whether arguments are wrongly decoded as codes. The upper read halves are filled with junk to expose missing masking. Bus latency and the message-posting and acknowledge-release delays vary, and a protocol model flags any out-of-order access. Poll-limit cases separate a limit that counts per message from one that counts across the whole run, and a disabled limit from an enabled one. A mid-run start pulse and a mid-run reset round out the runs.

// File: rtl/mboxPkg.sv
package mboxPkg;
  typedef enum logic [1:0] {
    TAG_MAJOR  = 2'd0,
    TAG_HEADER = 2'd1,
    TAG_ARG    = 2'd2
  } wordTag_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     capFull;
    logic     capLo;
    logic     capHi;
    logic     emit;
    logic     loadCount;
    logic     decCount;
    logic     pollInc;
    logic     pollClr;
    logic     setPass;
    logic     setFail;
    logic     clrFlags;
    wordTag_e tag;
  } dpStrobe_t;
endpackage

// File: rtl/mboxDatapath.sv
module mboxDatapath
  import mboxPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         ctl,
  input  logic [DATA_W-1:0] busRdata,
  input  logic [POLL_W-1:0] pollLimit,
  output logic [DATA_W-1:0] word,
  output logic              countIsOne,
  output logic              pollHit,
  output logic              msgValid,
  output wordTag_e          msgTag,
  output logic [DATA_W-1:0] msgWord,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0]   count;
  logic [POLL_W-1:0] pollCnt;

  assign countIsOne = (count == HALF'(1));
  assign pollHit    = (pollLimit != '0) && (pollCnt == pollLimit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      word     <= '0;
      count    <= '0;
      pollCnt  <= '0;
      msgValid <= 1'b0;
      msgTag   <= TAG_MAJOR;
      msgWord  <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      if (ctl.capFull) word <= busRdata;
      if (ctl.capLo)   word[HALF-1:0] <= busRdata[HALF-1:0];
      if (ctl.capHi)   word[DATA_W-1:HALF] <= busRdata[HALF-1:0];
      if (ctl.loadCount)     count <= word[HALF-1:0];
      else if (ctl.decCount) count <= count - 1'b1;
      if (ctl.pollClr)       pollCnt <= '0;
      else if (ctl.pollInc)  pollCnt <= pollCnt + 1'b1;
      msgValid <= ctl.emit;
      if (ctl.emit) begin
        msgTag  <= ctl.tag;
        msgWord <= word;
      end
      if (ctl.clrFlags) begin
        done <= 1'b0;
        pass <= 1'b0;
        fail <= 1'b0;
      end else begin
        if (ctl.setPass) begin done <= 1'b1; pass <= 1'b1; end
        if (ctl.setFail) begin done <= 1'b1; fail <= 1'b1; end
      end
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    msgValid |=> !msgValid);
  a_r6_pass_fail_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));
  a_r5_pass_has_done: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> done);
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !ctl.clrFlags) |=> done);
  a_r10_poll_bound: assert property (@(posedge clk) disable iff (rst)
    (pollLimit != '0 && $stable(pollLimit)) |-> (pollCnt < pollLimit));
endmodule

// File: rtl/mboxCtrl.sv
module mboxCtrl
  import mboxPkg::*;
#(
  parameter int                ADDR_W      = 20,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] STAT_OFF    = 20'hD0004,
  parameter logic [ADDR_W-1:0] LO_OFF      = 20'hD0032,
  parameter logic [ADDR_W-1:0] HI_OFF      = 20'hD0034,
  parameter logic [ADDR_W-1:0] ACK_OFF     = 20'hD0031,
  parameter logic [DATA_W-1:0] CODE_PASS   = 32'h07,
  parameter logic [DATA_W-1:0] CODE_FAIL   = 32'hFF,
  parameter logic [DATA_W-1:0] CODE_STREAM = 32'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busReady,
  input  logic              statBit,
  input  logic [DATA_W-1:0] word,
  input  logic              countIsOne,
  input  logic              pollHit,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output dpStrobe_t         ctl
);
  localparam int HALF = DATA_W / 2;

  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_RD_LO, S_RD_HI, S_ACK0, S_ACK_POLL, S_ACK1
  } state_e;

  state_e   state, stateNext;
  wordTag_e phase, phaseNext;

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    ctl       = '0;
    ctl.tag   = phase;
    busReq    = (state != S_IDLE);
    busWe     = 1'b0;
    busAddr   = STAT_OFF;
    busWdata  = '0;
    case (state)
      S_IDLE: if (start) begin
        ctl.clrFlags = 1'b1;
        ctl.pollClr  = 1'b1;
        phaseNext    = TAG_MAJOR;
        stateNext    = S_POLL;
      end
      S_POLL: if (busReady) begin
        if (!statBit) begin
          ctl.pollClr = 1'b1;
          stateNext   = S_RD_LO;
        end else if (pollHit) begin
          ctl.setFail = 1'b1;
          stateNext   = S_IDLE;
        end else begin
          ctl.pollInc = 1'b1;
        end
      end
      S_RD_LO: begin
        busAddr = LO_OFF;
        if (busReady) begin
          if (phase == TAG_MAJOR) begin
            ctl.capFull = 1'b1;
            stateNext   = S_ACK0;
          end else begin
            ctl.capLo = 1'b1;
            stateNext = S_RD_HI;
          end
        end
      end
      S_RD_HI: begin
        busAddr = HI_OFF;
        if (busReady) begin
          ctl.capHi = 1'b1;
          stateNext = S_ACK0;
        end
      end
      S_ACK0: begin
        busAddr = ACK_OFF;
        busWe   = 1'b1;
        if (busReady) stateNext = S_ACK_POLL;
      end
      S_ACK_POLL: if (busReady && statBit) stateNext = S_ACK1;
      S_ACK1: begin
        busAddr  = ACK_OFF;
        busWe    = 1'b1;
        busWdata = DATA_W'(1);
        if (busReady) begin
          ctl.emit  = 1'b1;
          stateNext = S_POLL;
          case (phase)
            TAG_MAJOR: begin
              if (word == CODE_PASS) begin
                ctl.setPass = 1'b1;
                stateNext   = S_IDLE;
              end else if (word == CODE_FAIL) begin
                ctl.setFail = 1'b1;
                stateNext   = S_IDLE;
              end else if (word == CODE_STREAM) begin
                phaseNext = TAG_HEADER;
              end
            end
            TAG_HEADER: begin
              ctl.loadCount = 1'b1;
              phaseNext = (word[HALF-1:0] == '0) ? TAG_MAJOR : TAG_ARG;
            end
            default: begin
              ctl.decCount = 1'b1;
              if (countIsOne) phaseNext = TAG_MAJOR;
            end
          endcase
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      phase <= TAG_MAJOR;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  a_r1_hold_request: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busReady) |=> (busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata)));
  a_r1_data_after_pending: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL && busReady && !statBit) |=> (busReq && !busWe && busAddr == LO_OFF));
  a_r4_release_then_write1: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACK_POLL && busReady && statBit) |=> (busReq && busWe && busWdata[0] && busAddr == ACK_OFF));
  a_r4_write0_then_poll: assert property (@(posedge clk) disable iff (rst)
    (busReq && busReady && busWe && !busWdata[0]) |=> (busReq && !busWe && busAddr == STAT_OFF));
endmodule

// File: rtl/mboxReader.sv
module mboxReader
  import mboxPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busRdata,
  output logic              msgValid,
  output logic [1:0]        msgTag,
  output logic [DATA_W-1:0] msgWord,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  dpStrobe_t         ctl;
  logic [DATA_W-1:0] word;
  logic              countIsOne;
  logic              pollHit;
  wordTag_e          tagOut;

  mboxCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .start(start), .busReady(busReady),
    .statBit(busRdata[0]), .word(word), .countIsOne(countIsOne),
    .pollHit(pollHit), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .ctl(ctl)
  );

  mboxDatapath #(.DATA_W(DATA_W), .POLL_W(POLL_W)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .busRdata(busRdata),
    .pollLimit(pollLimit), .word(word), .countIsOne(countIsOne),
    .pollHit(pollHit), .msgValid(msgValid), .msgTag(tagOut),
    .msgWord(msgWord), .done(done), .pass(pass), .fail(fail)
  );

  assign msgTag = tagOut;
endmodule

// File: tb/mboxReader_test.sv
module mboxReader_test;
  localparam int AW = 20, DW = 32, PW = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [PW-1:0] pollLimit = '0;
  logic busReady = 1'b0;
  logic [DW-1:0] busRdata = '0;
  logic busReq, busWe, msgValid, done, pass, fail;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata, msgWord;
  logic [1:0] msgTag;

  mboxReader uut (
    .clk(clk), .rst(rst), .start(start), .pollLimit(pollLimit),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .msgValid(msgValid),
    .msgTag(msgTag), .msgWord(msgWord), .done(done), .pass(pass), .fail(fail)
  );

  always #10 clk = ~clk;

  int checks = 0, errs = 0;
  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // mailbox model: 0 posting, 1 pending, 2 releasing, 3 awaiting write-1
  logic [31:0] q [0:31];
  int qLen = 0, qIdx = 0, mState = 0, postDelay = 0, cfgDelay = 0, rel = 0;
  int viol = 0, statusReads = 0, txn = 0, waitCnt = 0;
  bit readFlag = 0;

  task automatic resetModel();
    qIdx = 0; mState = 0; postDelay = cfgDelay; rel = 0;
    viol = 0; statusReads = 0; readFlag = 0;
  endtask

  task automatic serve();
    busRdata = '0;
    if (busWe) begin
      if (busAddr != 20'hD0031) viol++;
      else if (busWdata == 0) begin
        if (mState != 1 || !readFlag) viol++;
        else begin qIdx++; mState = 2; rel = 2; readFlag = 0; end
      end else if (busWdata == 1) begin
        if (mState != 3) viol++;
        else begin mState = 0; postDelay = cfgDelay; end
      end else viol++;
    end else if (busAddr == 20'hD0004) begin
      statusReads++;
      case (mState)
        0: begin
          if (qIdx >= qLen) busRdata = 32'h1;
          else if (postDelay > 0) begin postDelay--; busRdata = 32'h1; end
          else begin mState = 1; busRdata = 32'h0; end
        end
        1: busRdata = 32'hFFFF_FFFE;
        2: begin
          if (rel > 0) begin rel--; busRdata = 32'h0; end
          else begin mState = 3; busRdata = 32'h1; end
        end
        default: busRdata = 32'h1;
      endcase
    end else if (busAddr == 20'hD0032) begin
      if (mState != 1) viol++;
      readFlag = 1;
      busRdata = q[qIdx];
    end else if (busAddr == 20'hD0034) begin
      if (mState != 1) viol++;
      busRdata = {16'hDEAD, q[qIdx][31:16]};
    end else viol++;
  endtask

  // bus responder
  initial begin
    forever begin
      @(negedge clk);
      busReady = 1'b0;
      if (rst) waitCnt = 0;
      else if (busReq) begin
        if (waitCnt < txn % 3) waitCnt++;
        else begin waitCnt = 0; txn++; serve(); busReady = 1'b1; end
      end
    end
  end

  // output monitor and watchdog
  logic [31:0] gotW [0:31];
  int gotT [0:31];
  int gotN = 0, cycles = 0;
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (msgValid && gotN < 32) begin
        gotW[gotN] = msgWord; gotT[gotN] = int'(msgTag); gotN++;
      end
      if (cycles > 150000) begin
        errs++; checks++;
        $display("FAIL R12 watchdog expired: actual %0d expected <150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
      end
    end
  end

  task automatic runScenario(string req, int limit, int delay, bit midStart);
    logic [31:0] expW [0:31];
    int expT [0:31];
    int expN = 0, ph = 0, left = 0, term = 0, k = 0;
    bit reqSeen = 0;
    for (int i = 0; i < qLen && term == 0; i++) begin
      expW[expN] = q[i]; expT[expN] = ph; expN++;
      case (ph)
        0: if (q[i] == 32'h07) term = 1;
           else if (q[i] == 32'hFF) term = 2;
           else if (q[i] == 32'h08) ph = 1;
        1: begin left = int'(q[i][15:0]); ph = (left == 0) ? 0 : 2; end
        default: begin left--; if (left == 0) ph = 0; end
      endcase
    end
    pollLimit = PW'(limit); cfgDelay = delay; resetModel(); gotN = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R11", "flags cleared by start", {done, pass, fail}, 0);
    if (midStart) begin
      repeat (30) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done && k < 20000) begin @(negedge clk); k++; end
    repeat (10) begin @(negedge clk); if (busReq) reqSeen = 1; end
    check(term == 2 ? "R6" : "R5", "done", done, 1);
    check("R5", "pass", pass, term == 1);
    check(term == 0 ? "R10" : "R6", "fail", fail, term != 1);
    check("R5", "bus idle after finish", reqSeen, 0);
    check("R4", "protocol violations", viol, 0);
    check(req, "word count", gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(expT[i] == 0 ? "R2" : "R3", "word value", gotW[i], expW[i]);
      check("R9", "word tag", gotT[i], expT[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "reset outputs", {busReq, msgValid, done, pass, fail}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    q[0] = 32'h07; qLen = 1;
    runScenario("R5", 0, 0, 0);
    q[0] = 32'hFF; qLen = 1;
    runScenario("R6", 0, 1, 0);
    check("R11", "fail held while idle", fail, 1);
    q[0] = 32'h03; q[1] = 32'h1234_5678; q[2] = 32'h0; q[3] = 32'h07; qLen = 4;
    runScenario("R8", 0, 2, 0);

    for (int n = 0; n <= 4; n++) begin
      q[0] = 32'h08; q[1] = {16'(16'h40 + n), 16'(n)};
      for (int a = 0; a < n; a++)
        q[2 + a] = (a == 0) ? 32'h07 : (a == 1) ? 32'hFF : 32'hA500_0000 + 32'(a) * 32'h0001_0101;
      q[2 + n] = 32'h07; qLen = n + 3;
      runScenario("R7", 0, n, n == 3);
    end

    q[0] = 32'h08; q[1] = 32'hABCD_0002; q[2] = 32'h08; q[3] = 32'h07;
    q[4] = 32'h05; q[5] = 32'hFF; qLen = 6;
    runScenario("R7", 0, 1, 0);

    qLen = 0;
    runScenario("R10", 5, 0, 0);
    check("R10", "status reads before timeout", statusReads, 5);

    for (int i = 0; i < 4; i++) q[i] = 32'(i + 3);
    q[4] = 32'h07; qLen = 5;
    runScenario("R10", 12, 8, 0);
    q[0] = 32'h07; qLen = 1;
    runScenario("R10", 0, 40, 0);

    q[0] = 32'h08; q[1] = 32'h0000_0004; qLen = 2; cfgDelay = 0; resetModel();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (25) @(negedge clk);
    rst = 1'b1; @(negedge clk);
    check("R12", "mid-run reset", {busReq, msgValid, done, pass, fail}, 0);
    rst = 1'b0; @(negedge clk);
    q[0] = 32'h07; qLen = 1;
    runScenario("R12", 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule